// File: doc/BRIEF.md
# Receive Bit Slider

This block is a barrel shifter in a receive path. It applies a bit offset, chosen by the fabric, to incoming parallel words, so that bit-level skew inside one symbol can be removed. Coarse alignment by slipping whole symbols is done elsewhere. This block only handles the fine offset within a symbol.

Each accepted word is pushed into a history register. The newest word sits at the top and older bits move toward the bottom. For a datapath width W, the active window is the top 63+W bits of that register. Window bit 0 is the oldest bit and window bit 62+W is the most-significant bit of the newest word. A 6-bit select `s` picks window bits `s` up to `s+W-1` as the output word. In effect, the window is shifted right by `s`: higher-order bits move down into the low positions and the low bits that fall out are lost.

A static width code is captured while reset is held. The window spans 83, 79, 73 and 71 bits for widths 20, 16, 10 and 8. Because of this span, the largest 6-bit select never reaches past the window.

Top module: `bit_slider`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid` is 0, `out_data` is 0, and every history bit is 0.
- R2: `out_valid` equals `in_valid` one clock earlier. In a cycle with `in_valid` low, neither the history nor `out_data` changes.
- R3: `width_sel` sets the width W: 2'b00 gives 8, 2'b01 gives 10, 2'b10 gives 16 and 2'b11 gives 20. Only `in_data[W-1:0]` is used, and bit 0 is the earliest received bit.
- R4: After an accepted word, `out_data[i]` for i < W equals window bit `s+i`, where `s` is the select value sampled on that same edge. The window is the most recent 63+W received bits in arrival order, with bits never received read as 0.
- R5: With select 63, the output equals the word accepted on that edge. The window therefore spans 83, 79, 73 and 71 bits for widths 20, 16, 10 and 8, and no 6-bit select can exceed it.
- R6: For W < 20, bits `out_data[19:W]` are always 0.
- R7: `width_sel` is sampled only while reset is asserted. Changing it afterwards has no effect until the next reset.
- R8: A new select value applies to the next accepted word. A select change in a cycle without `in_valid` does not alter `out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; also captures the width code |
| width_sel | input | 2 | Datapath width code, sampled in reset |
| in_valid | input | 1 | Input word qualifier |
| in_data | input | 20 | Received word, low W bits used |
| shift_sel | input | 6 | Fabric bit offset into the window |
| out_valid | output | 1 | Output word qualifier, one cycle after `in_valid` |
| out_data | output | 20 | Aligned word, upper bits zero when W < 20 |

## Verification
On every cycle, the assertions check the one-cycle valid lag, that the output holds while input is idle, that the unused upper output bits are zero, that the captured width code stays fixed outside reset, and that select 63 returns the word just accepted. Only the bench's scenarios can show the correct bit selection at arbitrary offsets across word boundaries. The same applies to zero fill before the window is full, to a width code change after reset being ignored, and to the timing of a select change relative to accepted words. The bench checks these against a bit-stream model of the received data.

// File: rtl/bit_slider.sv
module bit_slider #(
  parameter int SEL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       width_sel,
  input  logic             in_valid,
  input  logic [19:0]      in_data,
  input  logic [SEL_W-1:0] shift_sel,
  output logic             out_valid,
  output logic [19:0]      out_data
);
  localparam int MAX_W = 20;
  localparam int HW    = (1 << SEL_W) - 1 + MAX_W;
  localparam int IW    = $clog2(HW + 1);

  logic [1:0]       cfg_q;
  logic [HW-1:0]    hist, hist_nxt, shifted;
  logic [IW-1:0]    wid, idx;
  logic [MAX_W-1:0] mask;

  always_ff @(posedge clk)
    if (!rst_n) cfg_q <= width_sel;

  always_comb begin
    case (cfg_q)
      2'd0:    begin wid = IW'(8);  hist_nxt = {in_data[7:0],  hist[HW-1:8]};  end
      2'd1:    begin wid = IW'(10); hist_nxt = {in_data[9:0],  hist[HW-1:10]}; end
      2'd2:    begin wid = IW'(16); hist_nxt = {in_data[15:0], hist[HW-1:16]}; end
      default: begin wid = IW'(20); hist_nxt = {in_data[19:0], hist[HW-1:20]}; end
    endcase
  end

  assign idx     = (IW'(MAX_W) - wid) + IW'(shift_sel);
  assign shifted = hist_nxt >> idx;
  assign mask    = {MAX_W{1'b1}} >> (IW'(MAX_W) - wid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        hist     <= hist_nxt;
        out_data <= shifted[MAX_W-1:0] & mask;
      end
    end
  end

  assert_valid_lag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_data)));
  assert_narrow_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q != 2'd3) |-> (out_data[19:16] == 4'd0));
  assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(cfg_q));
  assert_top_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (shift_sel == {SEL_W{1'b1}}) && cfg_q == 2'd3) |=> (out_data == $past(in_data)));
endmodule

// File: tb/sim_bit_slider.sv
module sim_bit_slider;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  width_sel = 2'd3;
  logic        in_valid = 1'b0;
  logic [19:0] in_data = '0;
  logic [5:0]  shift_sel = '0;
  logic        out_valid;
  logic [19:0] out_data;

  int checks = 0, fails = 0;
  int wcur = 20;
  bit sb [0:4095];
  int n = 0;

  bit_slider u0 (.clk(clk), .rst_n(rst_n), .width_sel(width_sel), .in_valid(in_valid),
                 .in_data(in_data), .shift_sel(shift_sel), .out_valid(out_valid),
                 .out_data(out_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic chk(string req, logic [19:0] act, logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] model(int s, int w);
    logic [19:0] r = '0;
    for (int i = 0; i < w; i++) begin
      int k = n - (63 + w) + s + i;
      r[i] = (k >= 0) ? sb[k] : 1'b0;
    end
    return r;
  endfunction

  task automatic do_reset(logic [1:0] code, int w);
    @(negedge clk);
    rst_n = 1'b0; width_sel = code; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; wcur = w; n = 0;
  endtask

  task automatic push(string req, logic [19:0] word, logic [5:0] s);
    in_valid = 1'b1; in_data = word; shift_sel = s;
    for (int i = 0; i < wcur; i++) begin sb[n] = word[i]; n++; end
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, {19'd0, out_valid}, 20'd1);
    chk(req, out_data, model(s, wcur));
  endtask

  task automatic t_reset;
    do_reset(2'd3, 20);
    chk("R1", {19'd0, out_valid}, 20'd0);
    chk("R1", out_data, 20'd0);
    push("R1", 20'hABCDE, 6'd0);
  endtask

  task automatic t_width(logic [1:0] code, int w, string req);
    do_reset(code, w);
    push(req, 20'hF1234, 6'd63);
    push(req, 20'h5A5A5, 6'd40);
    for (int j = 0; j < 6; j++) push(req, 20'h13579 * (j + 3), 6'(j * 11 + 2));
    push("R5", 20'h9C3E1, 6'd63);
    chk("R5", out_data, 20'h9C3E1 & ((20'd1 << w) - 20'd1));
    push("R4", 20'h0F0F0, 6'd0);
    if (w < 20) chk("R6", out_data >> w, 20'd0);
  endtask

  task automatic t_idle;
    logic [19:0] held;
    do_reset(2'd1, 10);
    repeat (9) push("R4", 20'h2B6D5, 6'd17);
    held = out_data;
    shift_sel = 6'd5;
    in_data = 20'hFFFFF;
    repeat (2) @(negedge clk);
    chk("R2", {19'd0, out_valid}, 20'd0);
    chk("R8", out_data, held);
    push("R8", 20'h00333, 6'd5);
  endtask

  task automatic t_cfg_late;
    do_reset(2'd0, 8);
    width_sel = 2'd3;
    for (int j = 0; j < 10; j++) push("R7", 20'hFFF00 | 20'(j * 37), 6'(j * 6));
    chk("R7", out_data >> 8, 20'd0);
  endtask

  initial begin
    t_reset;
    t_width(2'd0, 8,  "R3");
    t_width(2'd1, 10, "R3");
    t_width(2'd2, 16, "R4");
    t_width(2'd3, 20, "R4");
    t_idle;
    t_cfg_late;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule